// File: doc/BRIEF.md
# Four-Channel PWM Generator

This block produces four pulse-width-modulated outputs from a bank of registers on a small word-addressed bus. Four clock dividers each issue a one-cycle tick every N input clocks, where N is a 16-bit value in the divider's register. Each channel picks one of the four dividers through a field in its own duty register. It advances an 8-bit phase counter on that divider's ticks. The output is high while the phase is below the duty value, which gives a period of 256 ticks with the high part first.

Software enables each channel's output and time base separately. A bypass bit per channel holds an enabled output high. A write to a divider or duty register restarts the affected channels from phase 0 at once, and the period already running is abandoned. Writes happen on a single-cycle strobe. Reads are combinational on the same word address.

Top module: `pwm_quad`

## Requirements
- R1: After a synchronous reset all registers read zero and every output is low.
- R2: Register word map: word 0 holds output enables in bits 3:0 and bypass bits in 11:8. Word 1 holds time-base enables in bits 3:0. Words 2+n hold divider n in bits 15:0. Words 6+n hold channel n's duty in bits 7:0 and its divider select in bits 9:8. Reads return the stored fields with every other bit zero. Other words read zero, and writes to them change nothing.
- R3: A divider with a nonzero value N ticks once every N clocks. A value of 0 produces no ticks.
- R4: With output enabled, bypass clear and a nonzero divider N, the output is high for duty×N clocks and then low for (256−duty)×N clocks, repeating. A duty of 0 keeps it low.
- R5: The select field of a channel's duty register decides which divider clocks that channel.
- R6: A channel whose output enable is clear drives low one cycle later, whatever its bypass bit.
- R7: A channel with output enable and bypass set drives high one cycle later.
- R8: While a channel's time-base enable is clear its phase stays at 0. With a nonzero duty and divider, the output therefore stays high. Setting the bit again resumes normal periods.
- R9: A channel whose selected divider is 0 drives low unless bypassed.
- R10: A write to a channel's duty register, or to the divider it selects, returns its phase to 0 at the write edge. The output is high on the next cycle when the duty is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register word address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | Channel outputs, registered |

## Verification
The bench measures whole high and low runs on each channel. It covers duty values of 1, 64 and 255 and divider values of 1, 2 and 3. An off-by-one in the phase compare or the divider wrap would make these runs one tick or one clock too long. Re-pointing a channel to another divider catches a select field that is ignored or decoded from the wrong bits. A rewrite of an unchanged duty value during the low phase must bring the output high on the next cycle, which exposes a design that lets the running period finish. Zero divider, bypass over a zero divider, output enable clear over bypass, and a frozen time base each check that one control takes priority over another. The bench also writes an unused word and reads the register map back, looking for aliasing and for leaked bits.

// File: rtl/pwm_quad_pkg.sv
`timescale 1ns/1ps
package pwm_quad_pkg;
    localparam int CH_N    = 4;
    localparam int SEL_W   = $clog2(CH_N);
    localparam int DIV_W   = 16;
    localparam int DUTY_W  = 8;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 6;

    // word map
    localparam int WD_ENA   = 0;
    localparam int WD_CEN   = 1;
    localparam int WD_DIV0  = 2;
    localparam int WD_DUTY0 = WD_DIV0 + CH_N;
    localparam int BYP_LSB  = 8;
    localparam int SEL_LSB  = DUTY_W;

    typedef struct packed {
        logic              oe;
        logic              byp;
        logic              cen;
        logic [SEL_W-1:0]  sel;
        logic [DUTY_W-1:0] duty;
    } ch_cfg_t;

    // high while the phase is still inside the programmed high window
    function automatic logic in_high_window(logic [DUTY_W-1:0] phase,
                                            logic [DUTY_W-1:0] duty);
        return phase < duty;
    endfunction
endpackage

// File: rtl/pwm_quad_regs.sv
`timescale 1ns/1ps
module pwm_quad_regs
    import pwm_quad_pkg::*;
#(
    parameter int AddrW = ADDR_W,
    parameter int DataW = DATA_W,
    parameter int DivW  = DIV_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [AddrW-1:0]             bus_addr,
    input  logic                         bus_we,
    input  logic [DataW-1:0]             bus_wdata,
    output logic [DataW-1:0]             bus_rdata,
    output ch_cfg_t [CH_N-1:0]           cfg,
    output logic [CH_N-1:0][DivW-1:0]    div_val,
    output logic [CH_N-1:0]              div_wr,
    output logic [CH_N-1:0]              duty_wr
);
    logic [CH_N-1:0]              oe_q, byp_q, cen_q;
    logic [CH_N-1:0][SEL_W-1:0]   sel_q;
    logic [CH_N-1:0][DUTY_W-1:0]  duty_q;
    logic [CH_N-1:0][DivW-1:0]    div_q;
    logic                         ena_wr, cen_wr;
    logic                         unused_wdata;

    assign unused_wdata = ^bus_wdata[DataW-1:DivW];

    always_comb begin
        ena_wr = bus_we && (bus_addr == AddrW'(WD_ENA));
        cen_wr = bus_we && (bus_addr == AddrW'(WD_CEN));
        for (int i = 0; i < CH_N; i++) begin
            div_wr[i]  = bus_we && (bus_addr == AddrW'(WD_DIV0 + i));
            duty_wr[i] = bus_we && (bus_addr == AddrW'(WD_DUTY0 + i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q   <= '0;
            byp_q  <= '0;
            cen_q  <= '0;
            sel_q  <= '0;
            duty_q <= '0;
            div_q  <= '0;
        end else begin
            if (ena_wr) begin
                oe_q  <= bus_wdata[CH_N-1:0];
                byp_q <= bus_wdata[BYP_LSB +: CH_N];
            end
            if (cen_wr) begin
                cen_q <= bus_wdata[CH_N-1:0];
            end
            for (int i = 0; i < CH_N; i++) begin
                if (div_wr[i]) begin
                    div_q[i] <= bus_wdata[DivW-1:0];
                end
                if (duty_wr[i]) begin
                    duty_q[i] <= bus_wdata[DUTY_W-1:0];
                    sel_q[i]  <= bus_wdata[SEL_LSB +: SEL_W];
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AddrW'(WD_ENA)) begin
            bus_rdata[CH_N-1:0]         = oe_q;
            bus_rdata[BYP_LSB +: CH_N]  = byp_q;
        end
        if (bus_addr == AddrW'(WD_CEN)) begin
            bus_rdata[CH_N-1:0] = cen_q;
        end
        for (int i = 0; i < CH_N; i++) begin
            if (bus_addr == AddrW'(WD_DIV0 + i)) begin
                bus_rdata[DivW-1:0] = div_q[i];
            end
            if (bus_addr == AddrW'(WD_DUTY0 + i)) begin
                bus_rdata[DUTY_W-1:0]        = duty_q[i];
                bus_rdata[SEL_LSB +: SEL_W]  = sel_q[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < CH_N; i++) begin
            cfg[i].oe   = oe_q[i];
            cfg[i].byp  = byp_q[i];
            cfg[i].cen  = cen_q[i];
            cfg[i].sel  = sel_q[i];
            cfg[i].duty = duty_q[i];
        end
    end

    assign div_val = div_q;
endmodule

// File: rtl/pwm_quad_div.sv
`timescale 1ns/1ps
module pwm_quad_div #(
    parameter int DivW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DivW-1:0] div_val,
    input  logic            clr,
    output logic            tick
);
    logic [DivW-1:0] cnt;
    logic            live;
    logic            wrap;

    assign live = (div_val != '0);
    assign wrap = live && (cnt == div_val - DivW'(1));

    always_ff @(posedge clk) begin
        if (rst || clr || !live || wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DivW'(1);
        end
    end

    assign tick = wrap;
endmodule

// File: rtl/pwm_quad_chan.sv
`timescale 1ns/1ps
module pwm_quad_chan
    import pwm_quad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ch_cfg_t           cfg,
    input  logic              tick,
    input  logic              div_zero,
    input  logic              restart,
    output logic              pwm_q,
    output logic [DUTY_W-1:0] phase
);
    logic drive_hi;
    logic unused_sel;

    assign unused_sel = ^cfg.sel;

    always_ff @(posedge clk) begin
        if (rst || restart || !cfg.cen) begin
            phase <= '0;
        end else if (tick) begin
            phase <= phase + DUTY_W'(1);
        end
    end

    assign drive_hi = cfg.oe &&
                      (cfg.byp || (!div_zero && in_high_window(phase, cfg.duty)));

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= drive_hi;
        end
    end
endmodule

// File: rtl/pwm_quad.sv
`timescale 1ns/1ps
module pwm_quad
    import pwm_quad_pkg::*;
#(
    parameter int AddrW = ADDR_W,
    parameter int DataW = DATA_W,
    parameter int DivW  = DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AddrW-1:0] bus_addr,
    input  logic             bus_we,
    input  logic [DataW-1:0] bus_wdata,
    output logic [DataW-1:0] bus_rdata,
    output logic [CH_N-1:0]  pwm_out
);
    ch_cfg_t [CH_N-1:0]           cfg;
    logic [CH_N-1:0][DivW-1:0]    div_val;
    logic [CH_N-1:0]              div_wr, duty_wr, tick_vec;
    logic [CH_N-1:0]              oe_vec, byp_vec, cen_vec;
    logic [CH_N-1:0][SEL_W-1:0]   sel_vec;
    logic [CH_N-1:0][DUTY_W-1:0]  phase_vec;

    pwm_quad_regs #(.AddrW(AddrW), .DataW(DataW), .DivW(DivW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg       (cfg),
        .div_val   (div_val),
        .div_wr    (div_wr),
        .duty_wr   (duty_wr)
    );

    for (genvar d = 0; d < CH_N; d++) begin : g_div
        pwm_quad_div #(.DivW(DivW)) u_div (
            .clk     (clk),
            .rst     (rst),
            .div_val (div_val[d]),
            .clr     (div_wr[d]),
            .tick    (tick_vec[d])
        );
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_chan
        logic sel_tick, sel_zero, sel_restart;

        assign sel_tick    = tick_vec[cfg[c].sel];
        assign sel_zero    = (div_val[cfg[c].sel] == '0);
        assign sel_restart = div_wr[cfg[c].sel] || duty_wr[c];

        assign oe_vec[c]  = cfg[c].oe;
        assign byp_vec[c] = cfg[c].byp;
        assign cen_vec[c] = cfg[c].cen;
        assign sel_vec[c] = cfg[c].sel;

        pwm_quad_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .cfg      (cfg[c]),
            .tick     (sel_tick),
            .div_zero (sel_zero),
            .restart  (sel_restart),
            .pwm_q    (pwm_out[c]),
            .phase    (phase_vec[c])
        );
    end
endmodule

// File: rtl/pwm_quad_chk.sv
`timescale 1ns/1ps
module pwm_quad_chk
    import pwm_quad_pkg::*;
#(
    parameter int DivW = DIV_W
) (
    input logic                         clk,
    input logic                         rst,
    input logic [CH_N-1:0]              oe_vec,
    input logic [CH_N-1:0]              byp_vec,
    input logic [CH_N-1:0]              cen_vec,
    input logic [CH_N-1:0]              tick_vec,
    input logic [CH_N-1:0]              duty_wr,
    input logic [CH_N-1:0][SEL_W-1:0]   sel_vec,
    input logic [CH_N-1:0][DivW-1:0]    div_val,
    input logic [CH_N-1:0][DUTY_W-1:0]  phase_vec,
    input logic [CH_N-1:0]              pwm_out
);
    AST_RESET_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pwm_out == '0)) else $error("outputs not low after reset"); // R1

    for (genvar i = 0; i < CH_N; i++) begin : g_ast
        AST_NO_TICK_ZERO_DIV: assert property (@(posedge clk) disable iff (rst)
            (div_val[i] == '0) |-> !tick_vec[i]) else $error("tick from zero divider"); // R3

        AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
            !oe_vec[i] |=> !pwm_out[i]) else $error("disabled channel high"); // R6

        AST_BYPASS_HIGH: assert property (@(posedge clk) disable iff (rst)
            (oe_vec[i] && byp_vec[i]) |=> pwm_out[i]) else $error("bypass not high"); // R7

        AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (rst)
            !cen_vec[i] |=> (phase_vec[i] == '0)) else $error("phase moved while stopped"); // R8

        AST_ZERO_DIV_LOW: assert property (@(posedge clk) disable iff (rst)
            (oe_vec[i] && !byp_vec[i] && (div_val[sel_vec[i]] == '0)) |=> !pwm_out[i])
            else $error("zero divider channel high"); // R9

        AST_DUTY_RESTART: assert property (@(posedge clk) disable iff (rst)
            duty_wr[i] |=> (phase_vec[i] == '0)) else $error("no restart on duty write"); // R10
    end
endmodule

bind pwm_quad pwm_quad_chk #(.DivW(DivW)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .oe_vec    (oe_vec),
    .byp_vec   (byp_vec),
    .cen_vec   (cen_vec),
    .tick_vec  (tick_vec),
    .duty_wr   (duty_wr),
    .sel_vec   (sel_vec),
    .div_val   (div_val),
    .phase_vec (phase_vec),
    .pwm_out   (pwm_out)
);

// File: tb/test_pwm_quad.sv
`timescale 1ns/1ps
module test_pwm_quad;
    import pwm_quad_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [3:0]        pwm_out;

    always #2.5 clk = ~clk;

    pwm_quad i_pwm_quad (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        int    ch;
        int    hi;
        int    lo;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   pending = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_addr  = ADDR_W'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = ADDR_W'(a);
        #1;
        d = bus_rdata;
    endtask

    // driver side of the scoreboard: queue one expected period, wait until judged
    task automatic expect_period(int ch, int hi, int lo, string tag);
        exp_t e;
        e.ch = ch; e.hi = hi; e.lo = lo; e.tag = tag;
        exp_q.push_back(e);
        pending++;
        wait (pending == 0);
    endtask

    task automatic hold(int ch, logic v, int n, string tag);
        int bad = 0;
        repeat (2) @(negedge clk);
        repeat (n) begin
            @(negedge clk);
            if (pwm_out[ch] !== v) bad++;
        end
        chk(tag, bad, 0);
    endtask

    // monitor side: measure one full high run and the low run after it
    initial begin : monitor
        exp_t e;
        int   h;
        int   l;
        forever begin
            wait (pending > 0);
            e = exp_q.pop_front();
            h = 0;
            l = 0;
            @(negedge clk);
            while (pwm_out[e.ch] !== 1'b0) @(negedge clk);
            while (pwm_out[e.ch] !== 1'b1) @(negedge clk);
            while (pwm_out[e.ch] === 1'b1) begin h++; @(negedge clk); end
            while (pwm_out[e.ch] === 1'b0) begin l++; @(negedge clk); end
            chk({e.tag, " high run"}, h, e.hi);
            chk({e.tag, " low run"}, l, e.lo);
            pending--;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all): actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin : driver
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 outputs after reset", {28'd0, pwm_out}, 0);
        for (int w = 0; w < 10; w++) begin
            rd(w, d);
            chk("R1 register reset value", d, 0);
        end

        // R2: readback masks and unmapped word
        wr(0, 32'hFFFF_FFFF); rd(0, d); chk("R2 enable word readback", d, 32'h0000_0F0F);
        wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R2 time base word readback", d, 32'h0000_000F);
        wr(2, 32'hABCD_1234); rd(2, d); chk("R2 divider readback", d, 32'h0000_1234);
        wr(6, 32'hFFFF_FFFF); rd(6, d); chk("R2 duty readback", d, 32'h0000_03FF);
        wr(12, 32'hFFFF_FFFF); rd(12, d); chk("R2 unmapped word reads zero", d, 0);
        rd(2, d); chk("R2 unmapped write left divider", d, 32'h0000_1234);
        wr(0, 0); wr(1, 0); wr(2, 0); wr(6, 0);

        // configure dividers and channels
        wr(2, 2); wr(3, 3); wr(4, 1); wr(5, 0);
        wr(6, (0 << 8) | 64);
        wr(7, (1 << 8) | 1);
        wr(8, (2 << 8) | 255);
        wr(9, (1 << 8) | 100);
        wr(1, 32'hF);
        wr(0, 32'hF);

        // R3 R4: period shape for several duty and divider values
        expect_period(0, 128, 384, "R4 R3 ch0 duty64 div2");
        expect_period(1, 3, 765, "R4 R3 ch1 duty1 div3");
        expect_period(2, 255, 1, "R4 R3 ch2 duty255 div1");
        // R5: divider select
        expect_period(3, 300, 468, "R5 ch3 on divider1");
        wr(9, (0 << 8) | 100);
        expect_period(3, 200, 312, "R5 ch3 moved to divider0");
        wr(9, (0 << 8) | 0);
        hold(3, 1'b0, 1200, "R4 duty zero stays low");

        // R10: rewrite during low phase restarts the period
        @(negedge clk);
        while (pwm_out[1] !== 1'b1) @(negedge clk);
        repeat (50) @(negedge clk);
        chk("R10 ch1 low before rewrite", {31'd0, pwm_out[1]}, 0);
        wr(7, (1 << 8) | 1);
        @(negedge clk);
        chk("R10 ch1 high right after rewrite", {31'd0, pwm_out[1]}, 1);

        // R9: zero divider
        wr(4, 0);
        hold(2, 1'b0, 600, "R9 zero divider low");
        // R7: bypass
        wr(0, 32'h0000_040F);
        hold(2, 1'b1, 300, "R7 bypass over zero divider");
        wr(0, 32'h0000_050F);
        hold(0, 1'b1, 600, "R7 bypass ch0");
        // R6: enable clear beats bypass
        wr(0, 32'h0000_0500);
        hold(0, 1'b0, 200, "R6 ch0 disabled with bypass");
        hold(2, 1'b0, 200, "R6 ch2 disabled with bypass");

        // R8: time base stopped
        wr(0, 32'h0000_000F);
        wr(1, 32'hE);
        hold(0, 1'b1, 1200, "R8 stopped time base holds high");
        wr(1, 32'hF);
        expect_period(0, 128, 384, "R8 ch0 resumes");

        summary();
        $finish;
    end
endmodule